// File: doc/BRIEF.md
# Branch Condition Evaluator

A purely combinational decision unit for a small sequencer. Given two data operands and a condition code, it produces one bit telling the fetch logic whether a conditional jump should be followed. It supports six families of tests: an unconditional case, equality, ordered comparison in both signed and unsigned arithmetic, bitwise mask tests, a shifted bit-field test, and a test on one bit of a wide vector of external event lines.

Condition codes come in pairs. The even member is the positive test and the odd member is its exact complement. Codes outside the defined set never produce a taken result. Computing the target address and handling the pipeline are done elsewhere. This unit only answers the yes/no question.

Top module: `branch_eval`

## Requirements
- R1: Code 0x00 (always) gives taken_o = 1 for every operand and external value.
- R2: Code 0x01 and codes 0x14 to 0x1F are reserved and always give taken_o = 0.
- R3: Code 0x06 is taken when a_i equals b_i. Code 0x07 is taken when they differ.
- R4: Codes 0x08, 0x09, 0x0A and 0x0B compare a_i with b_i as two's-complement signed values: less, greater-or-equal, greater, less-or-equal.
- R5: Codes 0x0C, 0x0D, 0x0E and 0x0F apply the same four orderings as R4, with a_i and b_i treated as unsigned.
- R6: Code 0x02 is taken when (a_i & b_i) is nonzero. Code 0x03 is taken when it is zero.
- R7: Code 0x04 is taken when every bit set in a_i is also set in b_i, i.e. (a_i & b_i) == a_i. Code 0x05 is taken in every other case.
- R8: Code 0x10 is taken when the field is zero and code 0x11 when it is nonzero. The field is a_i shifted right by shamt_i, keeping its low (mwidth_i+1) bits. b_i has no effect on either code.
- R9: Code 0x12 is taken when ext_i[ext_sel_i] is 1. Code 0x13 is taken when that bit is 0.
- R10: When ext_sel_i is at or beyond EXT_W, the selected condition reads as 0. Code 0x12 is then not taken and code 0x13 is taken.
- R11: For every defined pair from 0x02/0x03 through 0x12/0x13, the odd code gives the complement of the even code for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | DATA_W (16) | First operand |
| b_i | input | DATA_W (16) | Second operand |
| cond_i | input | 5 | Condition code |
| shamt_i | input | SHIFT_W (4) | Right shift amount for the field test |
| mwidth_i | input | MASKW_W (4) | Field width minus one for the field test |
| ext_i | input | EXT_W (128) | External condition lines |
| ext_sel_i | input | SEL_W (7) | Index of the external line to test |
| taken_o | output | 1 | Branch taken |

## Verification
The bench uses operand pairs such as 0x8000 against 0x0001, chosen so that signed and unsigned orderings disagree. A design that mixed up the two compares would get the sign boundary wrong in one family. Equal operands are also applied to every ordering code, which catches a less-or-equal written as a strict less. The field test is driven at both extremes of shift and width, and with b_i changed, so that an off-by-one mask or a field that leaks b_i changes the result. A second instance with a narrower external vector exercises out-of-range selects, where a design that wraps the index would return a live bit. Every reserved code is swept to catch decode holes that fall through to a real test.

// File: rtl/branch_eval_pkg.sv
package branch_eval_pkg;
  localparam int unsigned COND_W = 5;

  typedef enum logic [COND_W-1:0] {
    C_ALWAYS   = 5'h00,
    C_AND_NZ   = 5'h02,
    C_AND_Z    = 5'h03,
    C_ALL_SET  = 5'h04,
    C_NALL_SET = 5'h05,
    C_EQ       = 5'h06,
    C_NE       = 5'h07,
    C_LT_S     = 5'h08,
    C_GE_S     = 5'h09,
    C_GT_S     = 5'h0A,
    C_LE_S     = 5'h0B,
    C_LT_U     = 5'h0C,
    C_GE_U     = 5'h0D,
    C_GT_U     = 5'h0E,
    C_LE_U     = 5'h0F,
    C_FLD_Z    = 5'h10,
    C_FLD_NZ   = 5'h11,
    C_EXT_T    = 5'h12,
    C_EXT_F    = 5'h13
  } cond_e;

  // predicate slots, indexed by cond[4:1]
  localparam int unsigned P_ALWAYS = 0;
  localparam int unsigned P_AND    = 1;
  localparam int unsigned P_ALL    = 2;
  localparam int unsigned P_EQ     = 3;
  localparam int unsigned P_LT_S   = 4;
  localparam int unsigned P_GT_S   = 5;
  localparam int unsigned P_LT_U   = 6;
  localparam int unsigned P_GT_U   = 7;
  localparam int unsigned P_FLD_Z  = 8;
  localparam int unsigned P_EXT    = 9;
  localparam int unsigned N_PRED   = 10;

  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
  } cmp_flags_t;
endpackage

// File: rtl/branch_eval_cmp.sv
module branch_eval_cmp
  import branch_eval_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output cmp_flags_t        flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0] diff;

  // one subtractor serves both orderings
  assign diff = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    flags_o.eq   = (a_i == b_i);
    flags_o.lt_u = diff[DATA_W];
    flags_o.lt_s = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : diff[MSB];
  end
endmodule

// File: rtl/branch_eval_mask.sv
module branch_eval_mask #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned MASKW_W = 4
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  input  logic [MASKW_W-1:0] mwidth_i,
  output logic               and_nz_o,
  output logic               all_set_o,
  output logic               fld_z_o
);
  logic [DATA_W-1:0] both;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] fmask;

  assign both      = a_i & b_i;
  assign and_nz_o  = |both;
  assign all_set_o = (both == a_i);
  assign shifted   = a_i >> shamt_i;

  // thermometer mask: bit k kept when k <= mwidth
  for (genvar k = 0; k < DATA_W; k++) begin : g_mask
    assign fmask[k] = (k <= int'(mwidth_i));
  end

  assign fld_z_o = ~|(shifted & fmask);
endmodule

// File: rtl/branch_eval_ext.sv
module branch_eval_ext #(
  parameter int unsigned EXT_W = 128,
  parameter int unsigned SEL_W = 7
) (
  input  logic [EXT_W-1:0] ext_i,
  input  logic [SEL_W-1:0] ext_sel_i,
  output logic             bit_o
);
  localparam int unsigned SPAN = 1 << SEL_W;

  if (EXT_W >= SPAN) begin : g_full
    assign bit_o = ext_i[ext_sel_i];
  end else begin : g_pad
    logic [SPAN-1:0] padded;
    assign padded = {{(SPAN - EXT_W){1'b0}}, ext_i};
    assign bit_o  = padded[ext_sel_i];
  end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import branch_eval_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned MASKW_W = 4,
  parameter int unsigned EXT_W   = 128,
  parameter int unsigned SEL_W   = 7
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [COND_W-1:0]  cond_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  input  logic [MASKW_W-1:0] mwidth_i,
  input  logic [EXT_W-1:0]   ext_i,
  input  logic [SEL_W-1:0]   ext_sel_i,
  output logic               taken_o
);
  localparam logic [COND_W-1:0] LAST_CODE = C_EXT_F;

  cmp_flags_t        flags;
  logic              and_nz, all_set, fld_z, ext_bit;
  logic [N_PRED-1:0] pred;
  logic [3:0]        slot;
  logic              inv, valid;

  branch_eval_cmp #(.DATA_W(DATA_W)) i_cmp (
    .a_i    (a_i),
    .b_i    (b_i),
    .flags_o(flags)
  );

  branch_eval_mask #(
    .DATA_W (DATA_W),
    .SHIFT_W(SHIFT_W),
    .MASKW_W(MASKW_W)
  ) i_mask (
    .a_i      (a_i),
    .b_i      (b_i),
    .shamt_i  (shamt_i),
    .mwidth_i (mwidth_i),
    .and_nz_o (and_nz),
    .all_set_o(all_set),
    .fld_z_o  (fld_z)
  );

  branch_eval_ext #(.EXT_W(EXT_W), .SEL_W(SEL_W)) i_ext (
    .ext_i    (ext_i),
    .ext_sel_i(ext_sel_i),
    .bit_o    (ext_bit)
  );

  always_comb begin
    pred           = '0;
    pred[P_ALWAYS] = 1'b1;
    pred[P_AND]    = and_nz;
    pred[P_ALL]    = all_set;
    pred[P_EQ]     = flags.eq;
    pred[P_LT_S]   = flags.lt_s;
    pred[P_GT_S]   = ~flags.lt_s & ~flags.eq;
    pred[P_LT_U]   = flags.lt_u;
    pred[P_GT_U]   = ~flags.lt_u & ~flags.eq;
    pred[P_FLD_Z]  = fld_z;
    pred[P_EXT]    = ext_bit;
  end

  // even code = predicate, odd code = complement; 0x01 has no partner
  assign slot    = cond_i[COND_W-1:1];
  assign inv     = cond_i[0];
  assign valid   = (cond_i <= LAST_CODE) && (cond_i != 5'h01);
  assign taken_o = valid & (pred[slot] ^ inv);
endmodule

// File: rtl/branch_eval_chk.sv
module branch_eval_chk
  import branch_eval_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned MASKW_W = 4,
  parameter int unsigned EXT_W   = 128,
  parameter int unsigned SEL_W   = 7
) (
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [COND_W-1:0]  cond_i,
  input logic [SHIFT_W-1:0] shamt_i,
  input logic [MASKW_W-1:0] mwidth_i,
  input logic [EXT_W-1:0]   ext_i,
  input logic [SEL_W-1:0]   ext_sel_i,
  input logic               taken_o,
  input logic               ext_bit,
  input logic               and_nz
);
  logic sel_bit;

  always_comb begin
    sel_bit = 1'b0;
    for (int k = 0; k < EXT_W; k++)
      if (k == int'(ext_sel_i)) sel_bit = ext_i[k];
  end

  always_comb begin
    // R1
    always_taken_chk: assert (cond_i != C_ALWAYS || taken_o);
    // R2
    reserved_idle_chk: assert (!(cond_i == 5'h01 || cond_i > 5'h13) || !taken_o);
    // R3
    eq_chk: assert (cond_i != C_EQ || taken_o == (a_i == b_i));
    // R4
    lt_signed_chk: assert (cond_i != C_LT_S || taken_o == ($signed(a_i) < $signed(b_i)));
    // R5
    lt_unsigned_chk: assert (cond_i != C_LT_U || taken_o == (a_i < b_i));
    // R6
    and_nz_chk: assert (cond_i != C_AND_Z || taken_o == !and_nz);
    // R9
    ext_true_chk: assert (cond_i != C_EXT_T || taken_o == sel_bit);
    // R10
    ext_range_chk: assert (int'(ext_sel_i) < EXT_W || !ext_bit);
  end
endmodule

bind branch_eval branch_eval_chk #(
  .DATA_W (DATA_W),
  .SHIFT_W(SHIFT_W),
  .MASKW_W(MASKW_W),
  .EXT_W  (EXT_W),
  .SEL_W  (SEL_W)
) i_branch_eval_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .cond_i   (cond_i),
  .shamt_i  (shamt_i),
  .mwidth_i (mwidth_i),
  .ext_i    (ext_i),
  .ext_sel_i(ext_sel_i),
  .taken_o  (taken_o),
  .ext_bit  (ext_bit),
  .and_nz   (and_nz)
);

// File: tb/test_branch_eval.sv
module test_branch_eval;
  localparam int CLK_PERIOD = 10;
  localparam int NARROW_W   = 100;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0]        a, b;
  logic [4:0]         cond;
  logic [3:0]         shamt, mw;
  logic [127:0]       ext;
  logic [6:0]         sel;
  logic [NARROW_W-1:0] ext_n;
  logic               taken, taken_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  branch_eval i_branch_eval (
    .a_i(a), .b_i(b), .cond_i(cond), .shamt_i(shamt), .mwidth_i(mw),
    .ext_i(ext), .ext_sel_i(sel), .taken_o(taken)
  );

  branch_eval #(.EXT_W(NARROW_W)) i_branch_eval_narrow (
    .a_i(a), .b_i(b), .cond_i(cond), .shamt_i(shamt), .mwidth_i(mw),
    .ext_i(ext_n), .ext_sel_i(sel), .taken_o(taken_n)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cond=%02h a=%04h b=%04h got=%0b exp=%0b", tag, cond, a, b, got, exp);
    end
  endtask

  // reference built from the requirement text
  function automatic logic ref_taken(input logic [4:0] c, input logic [15:0] x, input logic [15:0] y,
                                     input logic [3:0] sh, input logic [3:0] w, input logic eb);
    logic [15:0] fld;
    fld = (x >> sh) & ((17'h1 << (w + 1)) - 1);
    case (c)
      5'h00: return 1'b1;
      5'h02: return (x & y) != 0;
      5'h03: return (x & y) == 0;
      5'h04: return (x & y) == x;
      5'h05: return (x & y) != x;
      5'h06: return x == y;
      5'h07: return x != y;
      5'h08: return $signed(x) <  $signed(y);
      5'h09: return $signed(x) >= $signed(y);
      5'h0A: return $signed(x) >  $signed(y);
      5'h0B: return $signed(x) <= $signed(y);
      5'h0C: return x <  y;
      5'h0D: return x >= y;
      5'h0E: return x >  y;
      5'h0F: return x <= y;
      5'h10: return fld == 0;
      5'h11: return fld != 0;
      5'h12: return eb;
      5'h13: return !eb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] c);
    if (c == 5'h00) return "R1";
    if (c == 5'h01 || c > 5'h13) return "R2";
    if (c == 5'h02 || c == 5'h03) return "R6";
    if (c == 5'h04 || c == 5'h05) return "R7";
    if (c == 5'h06 || c == 5'h07) return "R3";
    if (c <= 5'h0B) return "R4";
    if (c <= 5'h0F) return "R5";
    if (c <= 5'h11) return "R8";
    return "R9";
  endfunction

  task automatic apply(input logic [4:0] c);
    cond = c;
    #1;
    chk(tag_of(c), taken, ref_taken(c, a, b, shamt, mw, ext[sel]));
  endtask

  task automatic sweep_all_codes(input logic [15:0] x, input logic [15:0] y);
    a = x; b = y;
    for (int c = 0; c < 32; c++) apply(5'(c));
  endtask

  task automatic t_idle;
    a = '0; b = '0; shamt = '0; mw = '0; ext = '0; ext_n = '0; sel = '0; cond = 5'h00;
    #1;
    chk("R1", taken, 1'b1);
    cond = 5'h01; #1;
    chk("R2", taken, 1'b0);
  endtask

  task automatic t_orderings;
    sweep_all_codes(16'h8000, 16'h0001);
    sweep_all_codes(16'h0001, 16'h8000);
    sweep_all_codes(16'h1234, 16'h1234);
    sweep_all_codes(16'hFFFF, 16'h0000);
    sweep_all_codes(16'h7FFF, 16'h8000);
  endtask

  task automatic t_masks;
    sweep_all_codes(16'h00F0, 16'h0F0F);
    sweep_all_codes(16'h0A00, 16'hFFFF);
    sweep_all_codes(16'h0000, 16'h0000);
  endtask

  task automatic t_field;
    a = 16'h8000; b = 16'h0000;
    shamt = 4'd15; mw = 4'd0;
    apply(5'h10); chk("R8", taken, 1'b0);
    apply(5'h11); chk("R8", taken, 1'b1);
    shamt = 4'd0; mw = 4'd14;
    apply(5'h10); chk("R8", taken, 1'b1);
    mw = 4'd15;
    apply(5'h10); chk("R8", taken, 1'b0);
    a = 16'h0030; shamt = 4'd4; mw = 4'd1;
    apply(5'h11); chk("R8", taken, 1'b1);
    b = 16'hFFFF;
    apply(5'h11); chk("R8", taken, 1'b1);
    shamt = 4'd6;
    apply(5'h10); chk("R8", taken, 1'b1);
  endtask

  task automatic t_ext;
    a = '0; b = '0;
    ext = '0; ext[127] = 1'b1; ext[0] = 1'b1;
    sel = 7'd127; apply(5'h12); chk("R9", taken, 1'b1);
    apply(5'h13); chk("R9", taken, 1'b0);
    sel = 7'd0; apply(5'h12); chk("R9", taken, 1'b1);
    sel = 7'd64; apply(5'h12); chk("R9", taken, 1'b0);
    apply(5'h13); chk("R9", taken, 1'b1);
  endtask

  task automatic t_ext_range;
    ext_n = '1;
    sel = 7'd99; cond = 5'h12; #1;
    chk("R9", taken_n, 1'b1);
    sel = 7'd100; cond = 5'h12; #1;
    chk("R10", taken_n, 1'b0);
    cond = 5'h13; #1;
    chk("R10", taken_n, 1'b1);
    sel = 7'd127; cond = 5'h12; #1;
    chk("R10", taken_n, 1'b0);
  endtask

  task automatic t_pairs;
    // R11: odd code complements the even code on the same inputs
    a = 16'hC3A5; b = 16'h5A3C; shamt = 4'd3; mw = 4'd5; sel = 7'd9; ext = '0; ext[9] = 1'b1;
    for (int p = 1; p <= 9; p++) begin
      logic te;
      cond = 5'(2 * p); #1; te = taken;
      cond = 5'(2 * p + 1); #1;
      chk("R11", taken, ~te);
    end
  endtask

  initial begin
    @(negedge clk);
    t_idle();
    t_orderings();
    t_masks();
    t_field();
    t_ext();
    t_ext_range();
    t_pairs();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule